// File: doc/BRIEF.md
# Two-Region Time-Slot Memory Arbiter

This block shares one memory port among fourteen requesters. The sharing follows a programmable schedule of sixty-four time slots. Every slot records the requester that owns it. A slot pointer steps through the schedule one slot per clock and returns to the start after the last slot. On each step the arbiter decides who gets the port. If the slot owner is asking for access, the owner wins. If the owner is idle, the slot goes to the lowest-numbered requester that is asking. If nobody is asking, no grant is given.

Two copies of the arbiter run side by side. One serves the external memory region and the other serves the internal region. Each copy has its own request and grant vectors and its own schedule. A single write port loads either schedule, one slot per cycle. It takes a region select, a slot index and a client number.

Top module: `dual_region_slot_arb`

## Requirements
- R1: When reset is asserted, both grant vectors are zero and both slot outputs read 63. Every schedule entry holds client 0, so a region whose schedule has not been written grants client 0 whenever client 0 requests.
- R2: After reset is released, each region's slot output gives the slot index of the current grant. It reads 0 after the first clock edge and rises by one on every edge, whether or not a grant was issued. After 63 it returns to 0.
- R3: When the client stored in the current slot requests, the grant one edge later is one-hot on that client. Bit i of a grant vector stands for client i.
- R4: When the slot owner does not request but at least one other client does, the grant goes to the lowest-indexed requesting client.
- R5: When no client of a region requests, that region's grant vector is zero one edge later.
- R6: A grant vector never has more than one bit set, and it only names a client that was requesting at the deciding edge.
- R7: A write with `wr_en` high stores `wr_client` (0 to 13) at slot `wr_slot` of the region chosen by `wr_region`. From the next time that slot comes up, the stored client is the owner of that slot.
- R8: `wr_region` 0 selects the external schedule and 1 selects the internal schedule. A write to one region leaves the other region's schedule unchanged.
- R9: A write whose client value is 14 or 15 is ignored. The slot keeps its previous owner.
- R10: A write to the slot being decided on the same edge does not change that decision. The new owner applies from the next pass of the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 14 | External-region requests, bit i = client i |
| int_req | input | 14 | Internal-region requests, bit i = client i |
| wr_en | input | 1 | Schedule write strobe |
| wr_region | input | 1 | 0 = external schedule, 1 = internal schedule |
| wr_slot | input | 6 | Slot index to write |
| wr_client | input | 4 | Client number to store (0 to 13 accepted) |
| ext_gnt | output | 14 | External-region one-hot grant (registered) |
| ext_slot | output | 6 | Slot index of the current external grant |
| int_gnt | output | 14 | Internal-region one-hot grant (registered) |
| int_slot | output | 6 | Slot index of the current internal grant |

## Verification
A corrupted schedule entry shows up as a wrong grant. This happens only when the pointer reaches that slot with the true owner requesting, so it can stay hidden for up to 64 cycles. The bench therefore sweeps whole passes with every client requesting. A pointer that skips or sticks shows at the slot output on the very next edge. A broken fallback shows one edge after any cycle in which the owner is idle and some other client requests. Writes are timed against the slot being decided, so a write that lands one pass early or late shows within a single pass.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int DEF_CLIENTS = 14;
  localparam int DEF_SLOTS   = 64;
  localparam int DEF_CW      = $clog2(DEF_CLIENTS);
  localparam int DEF_SW      = $clog2(DEF_SLOTS);

  typedef enum logic {
    REGION_EXT = 1'b0,
    REGION_INT = 1'b1
  } region_e;
endpackage

// File: rtl/slot_owner_table.sv
module slot_owner_table #(
  parameter int NC = slot_arb_pkg::DEF_CLIENTS,
  parameter int NS = slot_arb_pkg::DEF_SLOTS,
  parameter int CW = $clog2(NC),
  parameter int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] w_slot,
  input  logic [CW-1:0] w_client,
  input  logic [SW-1:0] r_slot,
  output logic [CW-1:0] r_owner
);
  localparam logic [CW-1:0] MAX_ID = CW'(NC - 1);

  logic [CW-1:0] owners [NS];
  logic          w_ok;

  assign w_ok = we && (w_client <= MAX_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) owners[i] <= '0;
    end else if (w_ok) begin
      owners[w_slot] <= w_client;
    end
  end

  assign r_owner = owners[r_slot];
endmodule

// File: rtl/slot_grant_pick.sv
module slot_grant_pick #(
  parameter int NC = slot_arb_pkg::DEF_CLIENTS,
  parameter int CW = $clog2(NC)
) (
  input  logic [CW-1:0] owner,
  input  logic [NC-1:0] req,
  output logic [NC-1:0] pick,
  output logic          owner_wants
);
  logic [NC-1:0] owner_hot;
  logic [NC-1:0] lowest;

  assign owner_hot   = {{(NC-1){1'b0}}, 1'b1} << owner;
  assign owner_wants = |(owner_hot & req);

  always_comb begin
    lowest = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (req[i]) begin
        lowest    = '0;
        lowest[i] = 1'b1;
      end
    end
  end

  assign pick = owner_wants ? owner_hot : lowest;
endmodule

// File: rtl/region_slot_arb.sv
module region_slot_arb #(
  parameter int NC = slot_arb_pkg::DEF_CLIENTS,
  parameter int NS = slot_arb_pkg::DEF_SLOTS,
  parameter int CW = $clog2(NC),
  parameter int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] req,
  input  logic          we,
  input  logic [SW-1:0] w_slot,
  input  logic [CW-1:0] w_client,
  output logic [NC-1:0] gnt,
  output logic [SW-1:0] slot
);
  localparam logic [SW-1:0] LAST = SW'(NS - 1);

  logic [SW-1:0] ptr;
  logic [CW-1:0] cur_owner;
  logic [NC-1:0] pick;
  logic          owner_wants;

  slot_owner_table #(.NC(NC), .NS(NS), .CW(CW), .SW(SW)) u_table (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .w_slot   (w_slot),
    .w_client (w_client),
    .r_slot   (ptr),
    .r_owner  (cur_owner)
  );

  slot_grant_pick #(.NC(NC), .CW(CW)) u_pick (
    .owner       (cur_owner),
    .req         (req),
    .pick        (pick),
    .owner_wants (owner_wants)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      gnt  <= '0;
      slot <= LAST;
    end else begin
      gnt  <= pick;
      slot <= ptr;
      ptr  <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/dual_region_slot_arb.sv
module dual_region_slot_arb #(
  parameter int NC = slot_arb_pkg::DEF_CLIENTS,
  parameter int NS = slot_arb_pkg::DEF_SLOTS,
  parameter int CW = $clog2(NC),
  parameter int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] ext_req,
  input  logic [NC-1:0] int_req,
  input  logic          wr_en,
  input  logic          wr_region,
  input  logic [SW-1:0] wr_slot,
  input  logic [CW-1:0] wr_client,
  output logic [NC-1:0] ext_gnt,
  output logic [SW-1:0] ext_slot,
  output logic [NC-1:0] int_gnt,
  output logic [SW-1:0] int_slot
);
  import slot_arb_pkg::*;

  logic we_ext;
  logic we_int;

  assign we_ext = wr_en && (region_e'(wr_region) == REGION_EXT);
  assign we_int = wr_en && (region_e'(wr_region) == REGION_INT);

  region_slot_arb #(.NC(NC), .NS(NS), .CW(CW), .SW(SW)) u_ext (
    .clk      (clk),
    .rst      (rst),
    .req      (ext_req),
    .we       (we_ext),
    .w_slot   (wr_slot),
    .w_client (wr_client),
    .gnt      (ext_gnt),
    .slot     (ext_slot)
  );

  region_slot_arb #(.NC(NC), .NS(NS), .CW(CW), .SW(SW)) u_int (
    .clk      (clk),
    .rst      (rst),
    .req      (int_req),
    .we       (we_int),
    .w_slot   (wr_slot),
    .w_client (wr_client),
    .gnt      (int_gnt),
    .slot     (int_slot)
  );
endmodule

// File: rtl/region_slot_arb_chk.sv
module region_slot_arb_chk #(
  parameter int NC = 14,
  parameter int NS = 64,
  parameter int CW = $clog2(NC),
  parameter int SW = $clog2(NS)
) (
  input logic          clk,
  input logic          rst,
  input logic [NC-1:0] req,
  input logic [CW-1:0] owner,
  input logic [NC-1:0] gnt,
  input logic [SW-1:0] slot
);
  localparam logic [SW-1:0] LAST = SW'(NS - 1);

  logic [NC-1:0] own_hot;
  logic          own_req;
  assign own_hot = {{(NC-1){1'b0}}, 1'b1} << owner;
  assign own_req = (own_hot & req) != '0;

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slot == (($past(slot) == LAST) ? '0 : $past(slot) + 1'b1)));

  // R3
  owner_win_chk: assert property (@(posedge clk) disable iff (rst)
    own_req |=> (gnt == $past(own_hot)));

  // R4
  fallback_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!own_req && req != '0) |=> (gnt == $past(req & (~req + 1'b1))));

  // R5
  idle_no_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (gnt == '0));

  // R6
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R6
  gnt_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gnt & ~$past(req)) == '0));
endmodule

bind region_slot_arb region_slot_arb_chk #(.NC(NC), .NS(NS), .CW(CW), .SW(SW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req   (req),
  .owner (cur_owner),
  .gnt   (gnt),
  .slot  (slot)
);

// File: tb/dual_region_slot_arb_bench.sv
`timescale 1ns/1ps
module dual_region_slot_arb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ext_req = '0, int_req = '0;
  logic        wr_en = 1'b0, wr_region = 1'b0;
  logic [5:0]  wr_slot = '0;
  logic [3:0]  wr_client = '0;
  logic [13:0] ext_gnt, int_gnt;
  logic [5:0]  ext_slot, int_slot;

  int n_tests = 0, n_fail = 0, exp_slot = 0;
  bit done = 0;
  logic [3:0] model [2][64];

  always #2 clk = ~clk;

  dual_region_slot_arb u_dual_region_slot_arb (
    .clk(clk), .rst(rst), .ext_req(ext_req), .int_req(int_req),
    .wr_en(wr_en), .wr_region(wr_region), .wr_slot(wr_slot), .wr_client(wr_client),
    .ext_gnt(ext_gnt), .ext_slot(ext_slot), .int_gnt(int_gnt), .int_slot(int_slot)
  );

  function automatic logic [13:0] pick(input logic [3:0] o, input logic [13:0] r);
    if (o < 14 && r[o]) return 14'(1) << o;
    for (int i = 0; i < 14; i++) if (r[i]) return 14'(1) << i;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (slot %0d)", tag, act, exp, exp_slot);
    end
  endtask

  // Called at a falling edge; drives inputs, lets one rising edge pass, checks.
  task automatic step(input logic [13:0] re, input logic [13:0] ri, input logic we,
                      input logic wreg, input int ws, input int wc, input string tag);
    logic [13:0] ee, ei;
    int cur;
    ext_req = re; int_req = ri;
    wr_en = we; wr_region = wreg; wr_slot = 6'(ws); wr_client = 4'(wc);
    cur = exp_slot;
    ee = pick(model[0][cur], re);
    ei = pick(model[1][cur], ri);
    if (we && wc < 14) model[wreg][ws] = 4'(wc);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk("R2 ext slot", 32'(ext_slot), 32'(cur));
    chk("R2 int slot", 32'(int_slot), 32'(cur));
    chk({tag, " ext gnt"}, 32'(ext_gnt), 32'(ee));
    chk({tag, " int gnt"}, 32'(int_gnt), 32'(ei));
    chk("R6 onehot", 32'($countones(ext_gnt) <= 1 && $countones(int_gnt) <= 1), 32'd1);
    exp_slot = (exp_slot + 1) % 64;
  endtask

  task automatic idle_to(input int s);
    while (exp_slot != s) step('0, '0, 1'b0, 1'b0, 0, 0, "R5");
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ext gnt", 32'(ext_gnt), 0);
    chk("R1 int gnt", 32'(int_gnt), 0);
    chk("R1 ext slot", 32'(ext_slot), 63);
    chk("R1 int slot", 32'(int_slot), 63);
    for (int r = 0; r < 2; r++) for (int s = 0; s < 64; s++) model[r][s] = '0;
    rst = 1'b0;
    exp_slot = 0;
    for (int i = 0; i < 64; i++) step('1, '1, 1'b0, 1'b0, 0, 0, "R1 zero table");
  endtask

  task automatic t_program;
    for (int i = 0; i < 64; i++) step('0, '0, 1'b1, 1'b0, i, i % 14, "R5 idle while writing");
    for (int i = 0; i < 64; i++) step('0, '0, 1'b1, 1'b1, i, (i * 5 + 3) % 14, "R5 idle while writing");
    for (int i = 0; i < 64; i++) step('1, '1, 1'b0, 1'b0, 0, 0, "R3 R7 R8 owner");
  endtask

  task automatic t_fallback;
    for (int i = 0; i < 64; i++) begin
      logic [13:0] me, mi;
      me = '1; mi = '1;
      me[model[0][exp_slot]] = 1'b0;
      mi[model[1][exp_slot]] = 1'b0;
      step(me, mi, 1'b0, 1'b0, 0, 0, "R4 owner idle");
    end
    for (int i = 0; i < 64; i++) step(14'h3000, 14'h0024, 1'b0, 1'b0, 0, 0, "R4 sparse req");
  endtask

  task automatic t_invalid;
    idle_to(0);
    step('0, '0, 1'b1, 1'b0, 10, 14, "R9 write 14");
    step('0, '0, 1'b1, 1'b1, 11, 15, "R9 write 15");
    idle_to(0);
    for (int i = 0; i < 64; i++) step('1, '1, 1'b0, 1'b0, 0, 0, "R9 kept owner");
  endtask

  task automatic t_inflight;
    idle_to(20);
    // old owner of external slot 20 is 6; new value 9 must wait a pass (R10)
    step('1, '1, 1'b1, 1'b0, 20, 9, "R10 same-edge write");
    chk("R10 old owner used", 32'(model[0][20]), 32'd9);
    idle_to(20);
    step('1, '1, 1'b0, 1'b0, 0, 0, "R10 next pass");
    chk("R10 ext gnt new owner", 32'(ext_gnt), 32'(14'(1) << 9));
    chk("R8 int slot 20 unchanged", 32'(int_gnt), 32'(14'(1) << ((20 * 5 + 3) % 14)));
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_program;
    t_fallback;
    t_invalid;
    t_inflight;
    idle_to(5);
    step('0, '0, 1'b0, 1'b0, 0, 0, "R5 no request");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule